// File: doc/BRIEF.md
# Registered Shift Unit with a Single Left-Shift Core

This block shifts a 32-bit operand B by a 5-bit amount. It supports three operations: logical left, logical right and arithmetic right. Only one left-shift datapath exists in the block. It is a logarithmic barrel of conditional power-of-two stages, and its low-end fill bit is an input. Right shifts reuse that same datapath. The operand is bit-reversed before the core and the core's output is reversed again afterwards. The fill bit is zero for the logical shifts and the operand's top bit for the arithmetic shift.

The shifted value is captured in an output register on the rising clock edge. It is visible one cycle after the inputs are presented. A synchronous active-high reset clears that register. The block has no handshake and accepts a new operation every cycle.

Top module: `shift_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes all zeros on that edge.
- R2: `result` reflects the `operand`, `amount` and `op` inputs sampled at the previous rising edge, and holds that value until the next edge.
- R3: With `op` = 2'b00, `result` equals `operand` shifted toward the most significant end by `amount`, with zeros entering the low bits.
- R4: With `op` = 2'b10, `result` equals `operand` shifted toward the least significant end by `amount`, with zeros entering the high bits.
- R5: With `op` = 2'b11, `result` equals `operand` shifted toward the least significant end by `amount`, with copies of `operand[31]` entering the high bits.
- R6: `op` = 2'b01 produces exactly the same result as `op` = 2'b00, a zero-filled left shift. A left shift never fills with the sign bit or with ones.
- R7: An `amount` of 0 returns `operand` unchanged under every `op` code.
- R8: With `op` = 2'b11 and `amount` = 31, every bit of `result` equals `operand[31]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| operand | input | 32 | Value to be shifted |
| amount | input | 5 | Number of bit positions to shift |
| op | input | 2 | Operation select: bit 1 = right shift, bit 0 = arithmetic fill (used only when right) |
| result | output | 32 | Registered shifted value |

## Verification
Every amount from 0 to 31 is applied under each of the four op codes. Each amount is paired with random operands, all zeros, all ones and a lone sign bit. The all-ones and sign-bit-only operands tell a zero fill apart from a sign fill. Left shifts must not pick up ones, and arithmetic right shifts must drag the sign across exactly `amount` positions. Random operands expose a reversal wired in the wrong place or a stage that shifts by the wrong distance. Amount 0 and amount 31 catch fencepost faults in the first and last stage.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int DATA_W = 32;
  localparam int AMT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    OP_LSL     = 2'b00,
    OP_LSL_ALT = 2'b01,
    OP_LSR     = 2'b10,
    OP_ASR     = 2'b11
  } shift_op_e;
endpackage

// File: rtl/bit_mirror.sv
// Optional bit-order reversal: a 2:1 select between the word and its mirror.
module bit_mirror #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] mirrored;

  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign mirrored[i] = din[W-1-i];
  end

  assign dout = en ? mirrored : din;
endmodule

// File: rtl/lshift_core.sv
// Logarithmic left shifter with a selectable fill bit for the vacated low bits.
module lshift_core #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] sa,
  input  logic          fill,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:AW];

  assign stage[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [W-1:0] moved;
    assign moved        = {stage[k][W-1-STEP:0], {STEP{fill}}};
    assign stage[k+1]   = sa[k] ? moved : stage[k];
  end

  assign dout = stage[AW];
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] amount,
  input  logic [1:0]    op,
  output logic [W-1:0]  result
);
  logic          go_right;
  logic          fill_bit;
  logic [W-1:0]  core_in;
  logic [W-1:0]  core_out;
  logic [W-1:0]  shifted;

  // op[1] selects the right-shift path; op[0] only matters on that path.
  assign go_right = op[1];
  assign fill_bit = go_right & op[0] & operand[W-1];

  bit_mirror #(.W(W)) u_mirror_in (
    .en   (go_right),
    .din  (operand),
    .dout (core_in)
  );

  lshift_core #(.W(W), .AW(AW)) u_core (
    .din  (core_in),
    .sa   (amount),
    .fill (fill_bit),
    .dout (core_out)
  );

  bit_mirror #(.W(W)) u_mirror_out (
    .en   (go_right),
    .din  (core_out),
    .dout (shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= shifted;
  end

  // R1: reset clears the output register
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (result == '0));

  // R7: zero amount is a pass-through for any op
  a_r7_zero_passthru: assert property (@(posedge clk) disable iff (rst)
    (amount == '0) |=> (result == $past(operand)));

  // R3 / R6: left shifts never put a one into bit 0 when the amount is nonzero
  a_r3_left_low_zero: assert property (@(posedge clk) disable iff (rst)
    (!op[1] && amount != '0) |=> (result[0] == 1'b0));

  // R4: logical right shifts clear the top bit when the amount is nonzero
  a_r4_lsr_top_zero: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b10 && amount != '0) |=> (result[W-1] == 1'b0));

  // R5: arithmetic right shift keeps the sign in the top bit
  a_r5_asr_keeps_sign: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b11) |=> (result[W-1] == $past(operand[W-1])));

  // R8: maximum arithmetic shift replicates the sign everywhere
  a_r8_asr_max_sign: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b11 && amount == AW'(W-1)) |=> (result == {W{$past(operand[W-1])}}));
endmodule

// File: tb/tb_shift_unit.sv
`timescale 1ns/1ps
module tb_shift_unit;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  operand;
  logic [AW-1:0] amount;
  logic [1:0]    op;
  logic [W-1:0]  result;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  shift_unit dut (
    .clk(clk), .rst(rst), .operand(operand),
    .amount(amount), .op(op), .result(result)
  );

  function automatic logic [W-1:0] model(input logic [1:0] o, input logic [W-1:0] b,
                                         input logic [AW-1:0] s);
    case (o)
      2'b10:   return b >> s;
      2'b11:   return $unsigned($signed(b) >>> s);
      default: return b << s;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h (op=%b amount=%0d operand=%h)",
               tag, got, exp, op, amount, operand);
    end
  endtask

  // Drive at the falling edge, register at the rising edge, sample at the next falling edge.
  task automatic apply(input string tag, input logic [1:0] o, input logic [W-1:0] b,
                       input logic [AW-1:0] s);
    op = o; operand = b; amount = s;
    @(negedge clk);
    check(tag, result, model(o, b, s));
  endtask

  task automatic sweep(input string tag, input logic [1:0] o);
    logic [W-1:0] pats [5];
    pats[0] = '0; pats[1] = '1; pats[2] = 32'h8000_0000;
    pats[3] = $urandom; pats[4] = $urandom | 32'h8000_0000;
    for (int p = 0; p < 5; p++)
      for (int s = 0; s < 32; s++)
        apply(tag, o, pats[p], AW'(s));
  endtask

  task automatic t_reset();  // R1
    operand = 32'hDEAD_BEEF; amount = 5'd3; op = 2'b00; rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset", result, '0);
    rst = 1'b0;
  endtask

  task automatic t_latency();  // R2
    apply("R2 first", 2'b00, 32'h0000_00F0, 5'd4);
    op = 2'b10; operand = 32'hF000_0000; amount = 5'd8;
    #2 check("R2 hold before edge", result, 32'h0000_0F00);
    @(negedge clk);
    check("R2 after edge", result, 32'h00F0_0000);
  endtask

  task automatic t_sll();   sweep("R3 lsl", 2'b00); endtask
  task automatic t_srl();   sweep("R4 lsr", 2'b10); endtask
  task automatic t_sra();   sweep("R5 asr", 2'b11); endtask
  task automatic t_alias(); sweep("R6 op01 as lsl", 2'b01);
    apply("R6 no one fill", 2'b01, 32'hFFFF_FFFF, 5'd16);
    check("R6 low half zero", result, 32'hFFFF_0000);
  endtask

  task automatic t_zero_amount();  // R7
    for (int o = 0; o < 4; o++) begin
      apply("R7 zero amount", 2'(o), 32'h9ABC_1234, 5'd0);
      check("R7 passthrough", result, 32'h9ABC_1234);
    end
  endtask

  task automatic t_sra_max();  // R8
    apply("R8 asr31 neg", 2'b11, 32'h8000_0001, 5'd31);
    check("R8 all ones", result, 32'hFFFF_FFFF);
    apply("R8 asr31 pos", 2'b11, 32'h7FFF_FFFF, 5'd31);
    check("R8 all zeros", result, 32'h0000_0000);
  endtask

  initial begin
    #2000000;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; operand = '0; amount = '0; op = '0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_sll();
    t_srl();
    t_sra();
    t_alias();
    t_zero_amount();
    t_sra_max();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule